// File: doc/BRIEF.md
# Thread Frame Synchronizer

This block keeps the bookkeeping for fine-grained, non-blocking threads in a decoupled dataflow processor. Each of a fixed number of frame slots holds one thread instance: a thread identifier and a join counter. An allocate request claims a free slot and loads its counter with the number of arguments the thread still needs. Each argument delivered to the slot lowers the counter. When the counter drains to zero the thread becomes runnable and joins a ready queue.

From the ready queue a pre-load unit takes threads in arrival order. After that, the block walks each thread through execute and then post-store, offering it to the matching unit with a valid/ready handshake and waiting for a done pulse that names the slot. Different threads may be in different phases at once, but a thread never skips or revisits a phase and cannot be cancelled while it runs. A free command returns a slot that is still waiting for arguments, such as the untaken branch of a conditional fork, or a slot that has finished post-store.

Every accept or refuse decision is made from the slot state held at the start of the cycle. The flags it produces (grant, busy and the error flags) are combinational in that cycle, and the state change lands on the next rising clock edge.

Top module: `thread_frame_sync`

## Requirements
- R1: After a synchronous active-low reset every slot is free. The pre-load, execute and post-store offers are all low, `seq_err` is low, and the first allocate is granted slot 0.
- R2: An allocate request is granted in the same cycle to the lowest-numbered free slot. `alloc_slot` carries that slot as a binary index. The slot stores `alloc_tid` and the count `alloc_cnt`.
- R3: If no slot is free, an allocate request raises `alloc_busy` with `alloc_gnt` low. The request is dropped and no slot changes.
- R4: Each accepted argument lowers its slot's count by one. A thread is offered to pre-load only from the cycle after its count reaches zero. It is never offered earlier.
- R5: An argument whose target slot is not waiting for arguments raises `arg_err` for that port and has no effect. Argument port k names its slot in `arg_slot[k*SW +: SW]`. When several ports hit one slot in the same cycle, lower-numbered ports are accepted first. A port that would take the count below zero is flagged and ignored.
- R6: The ready queue releases threads in the order their counts reached zero. Threads that reached zero in the same cycle leave in rising slot order.
- R7: An allocate with a count of zero makes the thread ready in the next cycle.
- R8: A thread moves from pre-load to execute to post-store and then to finished. It advances only on a done pulse for its slot in its current phase. A done pulse that names a slot in any other phase raises `seq_err` in that cycle and is ignored.
- R9: A free command succeeds only for a slot that is waiting for arguments or finished. For a slot that is ready or in any phase it raises `free_err` and changes nothing.
- R10: When several threads wait for execute, or for post-store, the lowest-numbered slot is offered first. Threads in different phases proceed independently.
- R11: A pre-load offer that is not taken holds the same slot in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_req | input | 1 | Allocate request |
| alloc_tid | input | TIDW | Thread identifier for the new frame |
| alloc_cnt | input | CNTW | Initial join count |
| alloc_gnt | output | 1 | Allocate accepted this cycle |
| alloc_busy | output | 1 | Allocate refused, no free slot |
| alloc_slot | output | SW | Slot being granted |
| arg_vld | input | NARG | Argument delivered, one bit per port |
| arg_slot | input | NARG*SW | Target slot per port |
| arg_err | output | NARG | Argument refused, per port |
| free_req | input | 1 | Free command |
| free_slot | input | SW | Slot to free |
| free_err | output | 1 | Free refused |
| pl_vld | output | 1 | Thread offered to pre-load |
| pl_slot | output | SW | Offered slot |
| pl_tid | output | TIDW | Offered thread identifier |
| pl_rdy | input | 1 | Pre-load unit takes the offer |
| pl_done | input | 1 | Pre-load finished |
| pl_done_slot | input | SW | Slot whose pre-load finished |
| ex_vld | output | 1 | Thread offered to execute |
| ex_slot | output | SW | Offered slot |
| ex_tid | output | TIDW | Offered thread identifier |
| ex_rdy | input | 1 | Execute unit takes the offer |
| ex_done | input | 1 | Execute finished |
| ex_done_slot | input | SW | Slot whose execute finished |
| ps_vld | output | 1 | Thread offered to post-store |
| ps_slot | output | SW | Offered slot |
| ps_tid | output | TIDW | Offered thread identifier |
| ps_rdy | input | 1 | Post-store unit takes the offer |
| ps_done | input | 1 | Post-store finished |
| ps_done_slot | input | SW | Slot whose post-store finished |
| seq_err | output | 1 | Done pulse for a slot not in that phase |

## Verification
Several properties are checked on every cycle:
- A running slot never returns to free in one step.
- A slot in pre-load can only stay there or move on to await execute.
- A waiting slot never holds a zero count, and no slot ever receives more decrements than its count.
- The ready queue never exceeds the slot count.
- An untaken pre-load offer holds its slot.

Some behaviour only the bench's scenarios can show:
- The grant order, and the busy refusal when every slot is full.
- The ordering of the ready queue across drain cycles and on ties.
- Arbitration between two argument ports hitting one slot.
- The refused free and misdirected done pulses leaving the phases untouched.

// File: rtl/tfs_pkg.sv
`timescale 1ns/1ps
// Shared types for the thread frame synchronizer.
// Assumes: slot life cycle is linear, free -> wait -> ready -> phases -> done.
package tfs_pkg;
    typedef enum logic [3:0] {
        SL_FREE  = 4'd0,
        SL_WAIT  = 4'd1,
        SL_READY = 4'd2,
        SL_PRELD = 4'd3,
        SL_EXQ   = 4'd4,
        SL_EXEC  = 4'd5,
        SL_PSQ   = 4'd6,
        SL_STORE = 4'd7,
        SL_DONE  = 4'd8
    } slot_st_t;
endpackage

// File: rtl/tfs_lowest.sv
`timescale 1ns/1ps
// Finds the lowest set bit of a request vector.
// Assumes: N >= 2; idx is meaningful only when found is high.
module tfs_lowest #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tfs_ready_queue.sv
`timescale 1ns/1ps
// In-order queue of slot indices whose join count has drained.
// Several slots may enter in one cycle; they are appended in rising index
// order after any pop. Assumes each slot is pushed at most once while
// queued, so NSLOT entries always suffice.
module tfs_ready_queue #(
    parameter int NSLOT = 8,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] push,
    input  logic             pop,
    output logic             nonempty,
    output logic [SW-1:0]    head
);
    logic [SW-1:0] q_q [NSLOT];
    logic [SW-1:0] q_n [NSLOT];
    logic [SW:0]   cnt_q;
    logic [SW:0]   cnt_n;

    assign nonempty = (cnt_q != '0);
    assign head     = q_q[0];

    // Next queue contents: drop the head on pop, then append new entries.
    always_comb begin
        q_n   = q_q;
        cnt_n = cnt_q;
        if (pop && nonempty) begin
            for (int i = 0; i < NSLOT - 1; i++) q_n[i] = q_q[i + 1];
            q_n[NSLOT - 1] = '0;
            cnt_n = cnt_q - 1'b1;
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (push[s]) begin
                q_n[cnt_n[SW-1:0]] = SW'(s);
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    // Queue registers with synchronous reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < NSLOT; i++) q_q[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            q_q   <= q_n;
        end
    end

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (SW+1)'(NSLOT));
endmodule

// File: rtl/tfs_frame_slot.sv
`timescale 1ns/1ps
// One frame slot: join counter, thread identifier and phase state.
// Assumes the top qualifies every event against this slot's current
// state, so each input pulse is legal when it arrives.
module tfs_frame_slot
    import tfs_pkg::*;
#(
    parameter int CNTW = 4,
    parameter int TIDW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_hit,
    input  logic [CNTW-1:0] alloc_cnt,
    input  logic [TIDW-1:0] alloc_tid,
    input  logic [CNTW-1:0] dec,
    input  logic            free_hit,
    input  logic            pl_take,
    input  logic            pl_done_hit,
    input  logic            ex_take,
    input  logic            ex_done_hit,
    input  logic            ps_take,
    input  logic            ps_done_hit,
    output slot_st_t        st,
    output logic [CNTW-1:0] cnt,
    output logic [TIDW-1:0] tid,
    output logic            drained
);
    slot_st_t        st_q;
    logic [CNTW-1:0] cnt_q;
    logic [TIDW-1:0] tid_q;

    assign st  = st_q;
    assign cnt = cnt_q;
    assign tid = tid_q;

    // Pulse when the thread becomes runnable at the coming edge.
    assign drained = (st_q == SL_FREE && alloc_hit && alloc_cnt == '0) ||
                     (st_q == SL_WAIT && !free_hit && dec != '0 && dec == cnt_q);

    // Slot life cycle; each state reacts only to its own event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SL_FREE;
            cnt_q <= '0;
            tid_q <= '0;
        end else begin
            unique case (st_q)
                SL_FREE: if (alloc_hit) begin
                    tid_q <= alloc_tid;
                    cnt_q <= alloc_cnt;
                    st_q  <= (alloc_cnt == '0) ? SL_READY : SL_WAIT;
                end
                SL_WAIT: if (free_hit) begin
                    st_q <= SL_FREE;
                end else begin
                    cnt_q <= cnt_q - dec;
                    if (dec == cnt_q) st_q <= SL_READY;
                end
                SL_READY: if (pl_take)     st_q <= SL_PRELD;
                SL_PRELD: if (pl_done_hit) st_q <= SL_EXQ;
                SL_EXQ:   if (ex_take)     st_q <= SL_EXEC;
                SL_EXEC:  if (ex_done_hit) st_q <= SL_PSQ;
                SL_PSQ:   if (ps_take)     st_q <= SL_STORE;
                SL_STORE: if (ps_done_hit) st_q <= SL_DONE;
                SL_DONE:  if (free_hit)    st_q <= SL_FREE;
                default:                   st_q <= SL_FREE;
            endcase
        end
    end

    // R9
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {SL_PRELD, SL_EXQ, SL_EXEC, SL_PSQ, SL_STORE}) |=> st_q != SL_FREE);
    // R8
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == SL_PRELD |=> st_q inside {SL_PRELD, SL_EXQ});
    // R4
    wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == SL_WAIT |-> cnt_q != '0);
    // R5
    dec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_WAIT) ? (dec <= cnt_q) : (dec == '0));
endmodule

// File: rtl/thread_frame_sync.sv
`timescale 1ns/1ps
// Thread frame synchronizer top: slot allocation, argument joining, ready
// queue and three-phase dispatch with valid/ready offers and done pulses.
// Assumes: every decision uses the slot states held at the start of the
// cycle; NARG is smaller than 2**CNTW.
module thread_frame_sync
    import tfs_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int CNTW  = 4,
    parameter int TIDW  = 6,
    parameter int NARG  = 2,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [TIDW-1:0]   alloc_tid,
    input  logic [CNTW-1:0]   alloc_cnt,
    output logic              alloc_gnt,
    output logic              alloc_busy,
    output logic [SW-1:0]     alloc_slot,
    input  logic [NARG-1:0]   arg_vld,
    input  logic [NARG*SW-1:0] arg_slot,
    output logic [NARG-1:0]   arg_err,
    input  logic              free_req,
    input  logic [SW-1:0]     free_slot,
    output logic              free_err,
    output logic              pl_vld,
    output logic [SW-1:0]     pl_slot,
    output logic [TIDW-1:0]   pl_tid,
    input  logic              pl_rdy,
    input  logic              pl_done,
    input  logic [SW-1:0]     pl_done_slot,
    output logic              ex_vld,
    output logic [SW-1:0]     ex_slot,
    output logic [TIDW-1:0]   ex_tid,
    input  logic              ex_rdy,
    input  logic              ex_done,
    input  logic [SW-1:0]     ex_done_slot,
    output logic              ps_vld,
    output logic [SW-1:0]     ps_slot,
    output logic [TIDW-1:0]   ps_tid,
    input  logic              ps_rdy,
    input  logic              ps_done,
    input  logic [SW-1:0]     ps_done_slot,
    output logic              seq_err
);
    slot_st_t        st_v  [NSLOT];
    logic [CNTW-1:0] cnt_v [NSLOT];
    logic [TIDW-1:0] tid_v [NSLOT];
    logic [CNTW-1:0] dec_v [NSLOT];

    logic [NSLOT-1:0] free_vec, exq_vec, psq_vec, drained_vec;
    logic [NSLOT-1:0] alloc_hit, free_hit, pl_take, pl_done_hit;
    logic [NSLOT-1:0] ex_take, ex_done_hit, ps_take, ps_done_hit;
    logic             any_free, free_ok;
    logic             bad_pl, bad_ex, bad_ps;

    // Per-slot state flags for the selectors.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            free_vec[s] = (st_v[s] == SL_FREE);
            exq_vec[s]  = (st_v[s] == SL_EXQ);
            psq_vec[s]  = (st_v[s] == SL_PSQ);
        end
    end

    tfs_lowest #(.N(NSLOT)) u_alloc_pick (
        .req(free_vec), .found(any_free), .idx(alloc_slot));

    assign alloc_gnt  = alloc_req && any_free;
    assign alloc_busy = alloc_req && !any_free;

    // Argument acceptance; lower ports claim remaining count first.
    always_comb begin
        logic [SW-1:0]   ks;
        logic [CNTW-1:0] prior;
        logic [NARG-1:0] acc;
        acc = '0;
        for (int s = 0; s < NSLOT; s++) dec_v[s] = '0;
        for (int k = 0; k < NARG; k++) begin
            ks    = arg_slot[k*SW +: SW];
            prior = '0;
            for (int j = 0; j < k; j++) begin
                if (acc[j] && arg_slot[j*SW +: SW] == ks) prior = prior + 1'b1;
            end
            acc[k] = arg_vld[k] && (st_v[ks] == SL_WAIT) && (prior < cnt_v[ks]);
            if (acc[k]) dec_v[ks] = dec_v[ks] + 1'b1;
        end
        arg_err = arg_vld & ~acc;
    end

    // Free is legal only for waiting or finished frames.
    assign free_ok  = (st_v[free_slot] == SL_WAIT) || (st_v[free_slot] == SL_DONE);
    assign free_err = free_req && !free_ok;

    tfs_ready_queue #(.NSLOT(NSLOT)) u_ready (
        .clk(clk), .rst_n(rst_n), .push(drained_vec),
        .pop(pl_vld && pl_rdy), .nonempty(pl_vld), .head(pl_slot));

    tfs_lowest #(.N(NSLOT)) u_ex_pick (
        .req(exq_vec), .found(ex_vld), .idx(ex_slot));
    tfs_lowest #(.N(NSLOT)) u_ps_pick (
        .req(psq_vec), .found(ps_vld), .idx(ps_slot));

    assign pl_tid = tid_v[pl_slot];
    assign ex_tid = tid_v[ex_slot];
    assign ps_tid = tid_v[ps_slot];

    // Misdirected done pulses are reported and dropped.
    assign bad_pl  = pl_done && (st_v[pl_done_slot] != SL_PRELD);
    assign bad_ex  = ex_done && (st_v[ex_done_slot] != SL_EXEC);
    assign bad_ps  = ps_done && (st_v[ps_done_slot] != SL_STORE);
    assign seq_err = bad_pl || bad_ex || bad_ps;

    // Decode of per-slot events from the shared command buses.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            alloc_hit[s]   = alloc_gnt && (alloc_slot == SW'(s));
            free_hit[s]    = free_req && free_ok && (free_slot == SW'(s));
            pl_take[s]     = pl_vld && pl_rdy && (pl_slot == SW'(s));
            ex_take[s]     = ex_vld && ex_rdy && (ex_slot == SW'(s));
            ps_take[s]     = ps_vld && ps_rdy && (ps_slot == SW'(s));
            pl_done_hit[s] = pl_done && !bad_pl && (pl_done_slot == SW'(s));
            ex_done_hit[s] = ex_done && !bad_ex && (ex_done_slot == SW'(s));
            ps_done_hit[s] = ps_done && !bad_ps && (ps_done_slot == SW'(s));
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        tfs_frame_slot #(.CNTW(CNTW), .TIDW(TIDW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_hit(alloc_hit[g]), .alloc_cnt(alloc_cnt), .alloc_tid(alloc_tid),
            .dec(dec_v[g]), .free_hit(free_hit[g]),
            .pl_take(pl_take[g]), .pl_done_hit(pl_done_hit[g]),
            .ex_take(ex_take[g]), .ex_done_hit(ex_done_hit[g]),
            .ps_take(ps_take[g]), .ps_done_hit(ps_done_hit[g]),
            .st(st_v[g]), .cnt(cnt_v[g]), .tid(tid_v[g]),
            .drained(drained_vec[g]));
    end

    // R11
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_vld && !pl_rdy) |=> (pl_vld && $stable(pl_slot)));
    // R3
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_busy |-> ($countones(free_vec) == 0));
endmodule

// File: tb/thread_frame_sync_test.sv
`timescale 1ns/1ps
module thread_frame_sync_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       alloc_req;  logic [5:0] alloc_tid;  logic [3:0] alloc_cnt;
    logic       alloc_gnt, alloc_busy; logic [2:0] alloc_slot;
    logic [1:0] arg_vld;    logic [5:0] arg_slot;   logic [1:0] arg_err;
    logic       free_req;   logic [2:0] free_slot;  logic free_err;
    logic       pl_vld, pl_rdy, pl_done; logic [2:0] pl_slot, pl_done_slot; logic [5:0] pl_tid;
    logic       ex_vld, ex_rdy, ex_done; logic [2:0] ex_slot, ex_done_slot; logic [5:0] ex_tid;
    logic       ps_vld, ps_rdy, ps_done; logic [2:0] ps_slot, ps_done_slot; logic [5:0] ps_tid;
    logic       seq_err;

    thread_frame_sync uut (.*);

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed {
        logic al; logic [3:0] cn; logic [5:0] td;
        logic v0; logic [2:0] s0; logic v1; logic [2:0] s1;
        logic eg; logic [2:0] es; logic e0; logic e1; logic ep; logic [2:0] eps;
    } vec_t;

    // Stimulus and expected combinational response per cycle after reset.
    localparam vec_t TAB [6] = '{
        '{1'b1, 4'd2, 6'd5, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{1'b1, 4'd1, 6'd6, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0},
        '{1'b0, 4'd0, 6'd0, 1'b1, 3'd0, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0},
        '{1'b0, 4'd0, 6'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0},
        '{1'b1, 4'd0, 6'd7, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b0, 4'd0, 6'd0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_req = 0; alloc_tid = 0; alloc_cnt = 0;
        arg_vld = 0; arg_slot = 0; free_req = 0; free_slot = 0;
        pl_rdy = 0; pl_done = 0; pl_done_slot = 0;
        ex_rdy = 0; ex_done = 0; ex_done_slot = 0;
        ps_rdy = 0; ps_done = 0; ps_done_slot = 0;
    endtask

    task automatic next();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic alloc(input int cnt, input int tid);
        alloc_req = 1; alloc_cnt = 4'(cnt); alloc_tid = 6'(tid);
    endtask

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        @(negedge clk);
        do_reset();
        // R1 reset state
        #1;
        chk("R1", "pl_vld", pl_vld, 0); chk("R1", "ex_vld", ex_vld, 0);
        chk("R1", "ps_vld", ps_vld, 0); chk("R1", "seq_err", seq_err, 0);

        // Vector table: allocation, joining, errors, ready order
        for (int i = 0; i < 6; i++) begin
            alloc_req = TAB[i].al; alloc_cnt = TAB[i].cn; alloc_tid = TAB[i].td;
            arg_vld = {TAB[i].v1, TAB[i].v0}; arg_slot = {TAB[i].s1, TAB[i].s0};
            #1;
            chk("R2", "alloc_gnt", alloc_gnt, TAB[i].eg);
            if (TAB[i].eg) chk("R2", "alloc_slot", alloc_slot, TAB[i].es);
            chk("R5", "arg_err0", arg_err[0], TAB[i].e0);
            chk("R5", "arg_err1", arg_err[1], TAB[i].e1);
            chk("R4", "pl_vld", pl_vld, TAB[i].ep);
            if (TAB[i].ep) chk("R6", "pl_slot", pl_slot, TAB[i].eps);
            next();
        end
        // R6 R7 drain order: slot 0 and 1 drained together, slot 2 allocated ready
        for (int i = 0; i < 3; i++) begin
            pl_rdy = 1; #1;
            chk("R6", "pl_slot", pl_slot, i);
            chk("R7", "pl_tid", pl_tid, 5 + i);
            next();
        end
        #1; chk("R6", "pl_vld empty", pl_vld, 0);

        // R1 R2 R3 full table
        do_reset();
        for (int i = 0; i < 8; i++) begin
            alloc(1, i); #1;
            chk("R1", "alloc_slot", alloc_slot, i);
            chk("R2", "alloc_gnt", alloc_gnt, 1);
            next();
        end
        alloc(1, 30); #1;
        chk("R3", "alloc_busy", alloc_busy, 1); chk("R3", "alloc_gnt", alloc_gnt, 0);
        next();
        free_req = 1; free_slot = 3; alloc(1, 31); #1;
        chk("R9", "free_err wait", free_err, 0);
        chk("R3", "busy same cycle as free", alloc_busy, 1);
        next();
        alloc(2, 32); #1;
        chk("R2", "reuse slot", alloc_slot, 3);
        arg_vld = 2'b01; arg_slot = {3'd0, 3'd5}; #1;
        chk("R3", "slot5 untouched", arg_err[0], 0);
        next();
        #1; chk("R4", "pl_vld", pl_vld, 1); chk("R4", "pl_slot", pl_slot, 5);
        chk("R3", "pl_tid", pl_tid, 5);

        // R4 R5 argument arbitration
        do_reset();
        alloc(1, 1); next();
        alloc(3, 2); arg_vld = 2'b11; arg_slot = {3'd0, 3'd0}; #1;
        chk("R5", "port0 ok", arg_err[0], 0); chk("R5", "port1 over", arg_err[1], 1);
        next();
        arg_vld = 2'b11; arg_slot = {3'd1, 3'd1}; #1;
        chk("R5", "both ok", arg_err, 0); chk("R4", "pl_slot", pl_slot, 0);
        next();
        pl_rdy = 1; arg_vld = 2'b11; arg_slot = {3'd1, 3'd4}; #1;
        chk("R5", "free target", arg_err[0], 1); chk("R5", "last arg", arg_err[1], 0);
        chk("R4", "head still 0", pl_slot, 0);
        next();
        #1; chk("R4", "slot1 offered", pl_vld && pl_slot == 1, 1);

        // R7 R8 R9 R10 R11 phases
        do_reset();
        alloc(0, 9); next();
        alloc(0, 10); #1;
        chk("R7", "ready next cycle", pl_vld && pl_slot == 0, 1); next();
        #1; chk("R11", "held", pl_vld && pl_slot == 0, 1); next();
        pl_rdy = 1; #1; chk("R8", "pl_tid", pl_tid, 9); next();
        pl_rdy = 1; free_req = 1; free_slot = 0; #1;
        chk("R8", "pl_slot", pl_slot, 1); chk("R9", "free running", free_err, 1); next();
        pl_done = 1; pl_done_slot = 1; ex_done = 1; ex_done_slot = 0; #1;
        chk("R8", "seq_err", seq_err, 1); chk("R8", "ex_vld", ex_vld, 0); next();
        pl_done = 1; pl_done_slot = 0; #1;
        chk("R8", "ex offer", ex_vld && ex_slot == 1, 1); chk("R8", "seq ok", seq_err, 0); next();
        ex_rdy = 1; #1;
        chk("R10", "lowest ex", ex_slot, 0); chk("R10", "ex_tid", ex_tid, 9);
        chk("R9", "slot0 not freed", ex_vld, 1); next();
        ex_rdy = 1; #1; chk("R10", "ex second", ex_slot, 1); next();
        ex_done = 1; ex_done_slot = 1; #1;
        chk("R10", "ex empty", ex_vld, 0); chk("R8", "ps_vld", ps_vld, 0); next();
        ps_rdy = 1; ex_done = 1; ex_done_slot = 0; #1;
        chk("R10", "ps slot", ps_slot, 1); chk("R10", "ps_tid", ps_tid, 10); next();
        ps_rdy = 1; free_req = 1; free_slot = 1; #1;
        chk("R10", "ps slot0", ps_vld && ps_slot == 0, 1);
        chk("R9", "free store", free_err, 1); next();
        ps_done = 1; ps_done_slot = 1; #1; chk("R8", "ps_done ok", seq_err, 0); next();
        free_req = 1; free_slot = 1; ps_done = 1; ps_done_slot = 0; #1;
        chk("R9", "free done", free_err, 0); next();
        alloc(1, 3); #1;
        chk("R9", "freed slot reused", alloc_slot, 1); chk("R2", "gnt", alloc_gnt, 1);
        next();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule